// File: doc/BRIEF.md
# Cache Range Flush Engine

One instance of this engine sits at each level of a cache hierarchy and makes the level coherent with memory for an arbitrary byte range before a near-memory accelerator touches that range. A request gives a base address and a byte count from 4 bytes up to 8 KB. The engine rounds the base down to a line boundary. It then looks up the tag array once per line, stepping from the first overlapping line to the last. For each hit it pushes one command into the level's write buffer: a writeback for a dirty line or an invalidate for a clean line. In the same cycle it clears the line's valid bit.

After the last line it pushes the flush request itself into the write buffer. Every eviction therefore sits ahead of it. One cycle later the engine hands the request on. At inner levels the request goes to the next level down. At the outermost level, selected by a parameter, it is returned to the requester as a completion. The engine takes one request at a time. A full write buffer pauses the walk without dropping any line.

Top module: `range_flush_engine`

## Requirements
- R1: After reset the engine is ready (`req_ready`=1) and `lk_valid`, `lk_clr`, `wb_valid`, `fwd_valid` and `cpl_valid` are all 0.
- R2: An accepted request produces exactly one lookup per line index from floor(base/LINE_BYTES) to floor((base+size-1)/LINE_BYTES), in ascending order, and no other lookup.
- R3: A lookup that hits a dirty line asserts `lk_clr` in the lookup cycle. In the next cycle it pushes a write-buffer entry with `wb_cmd`=1 (writeback) and `wb_addr` = line index × LINE_BYTES.
- R4: A lookup that hits a clean line asserts `lk_clr`. In the next cycle it pushes an entry with `wb_cmd`=2 (invalidate) and the line address. A missing line produces no entry.
- R5: After the line commands of a request, exactly one entry with `wb_cmd`=3 carries the unrounded base and size. No line command of that request follows it.
- R6: One cycle after the `wb_cmd`=3 entry, an inner level (IS_LAST=0) pulses `fwd_valid` with the request's base and size. An outermost level (IS_LAST=1) pulses `cpl_valid` instead. The two are never both high.
- R7: With the write buffer never full, the hand-on pulse appears exactly N+2 cycles after the accepting edge, where N is the number of lines, whether or not any line hits.
- R8: While `wb_full` is high, no lookup is made and no new entry is started. Each cycle of `wb_full` delays completion by one cycle and skips no line.
- R9: `req_ready` is low from acceptance until the request has been handed on. A `req_valid` seen while busy is ignored.
- R10: Every line command address is aligned to LINE_BYTES. An unaligned range that crosses a line boundary is looked up on both lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Flush request present |
| req_addr | input | ADDR_W | Range base address (byte) |
| req_size | input | SIZE_W | Range length in bytes |
| req_ready | output | 1 | Engine idle; request accepted when both high |
| lk_valid | output | 1 | Tag lookup this cycle |
| lk_line | output | ADDR_W | Line index being looked up |
| lk_hit | input | 1 | Tag array: line present |
| lk_dirty | input | 1 | Tag array: line modified |
| lk_clr | output | 1 | Clear the valid bit of `lk_line` at this edge |
| wb_full | input | 1 | Write buffer cannot take an entry |
| wb_valid | output | 1 | Write-buffer push |
| wb_cmd | output | 2 | 1 writeback, 2 invalidate, 3 flush request |
| wb_addr | output | ADDR_W | Line address, or range base for a flush |
| wb_size | output | SIZE_W | LINE_BYTES, or range size for a flush |
| fwd_valid | output | 1 | Request handed to the next level |
| cpl_valid | output | 1 | Completion returned (outermost level) |
| out_addr | output | ADDR_W | Base of the handed-on request |
| out_size | output | SIZE_W | Size of the handed-on request |

## Verification
The walk is exercised with a set of ranges:
- A 4-byte range inside one line.
- An aligned four-line span holding one clean and one dirty line.
- An unaligned 8-byte range straddling a boundary.
- A two-line span starting on a dirty line.
- A full 8 KB span of 128 lines.
- A tiny unaligned range that hits two lines.

Comparing lookup count, first index, ordering and hit mix across these separates rounding errors at the start from errors at the end, and off-by-one stepping. It also separates writeback/invalidate confusion from dropped hits. A stalled run shows whether back-pressure skips lines or lengthens the walk by exactly the stall. A request injected mid-walk shows whether a busy engine leaks a second flush. A second instance built as the outermost level confirms that completion replaces forwarding.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
  typedef enum logic [1:0] {
    WB_NONE       = 2'd0,
    WB_WRITEBACK  = 2'd1,
    WB_INVALIDATE = 2'd2,
    WB_FLUSH      = 2'd3
  } wb_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WALK,
    ST_FLUSH,
    ST_NOTE
  } walk_state_e;
endpackage

// File: rtl/rfe_range.sv
module rfe_range #(
  parameter int ADDR_W  = 32,
  parameter int SIZE_W  = 14,
  parameter int LINE_LG = 6
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [SIZE_W-1:0] size,
  output logic [ADDR_W-1:0] first_idx,
  output logic [ADDR_W-1:0] last_idx
);
  logic [ADDR_W-1:0] size_ext;
  logic [ADDR_W-1:0] end_addr;

  always_comb begin
    size_ext  = {{(ADDR_W-SIZE_W){1'b0}}, size};
    end_addr  = base + size_ext - {{(ADDR_W-1){1'b0}}, 1'b1};
    first_idx = base >> LINE_LG;
    last_idx  = end_addr >> LINE_LG;
  end
endmodule

// File: rtl/rfe_walker.sv
module rfe_walker
  import rfe_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] first_idx,
  input  logic [ADDR_W-1:0] last_idx,
  input  logic              wb_full,
  input  logic              lk_hit,
  output logic              busy,
  output logic              lk_valid,
  output logic [ADDR_W-1:0] lk_idx,
  output logic              lk_clr,
  output logic              flush_go,
  output logic              notify_go
);
  walk_state_e       st;
  logic [ADDR_W-1:0] cur_q;
  logic [ADDR_W-1:0] stop_q;

  always_comb begin
    busy      = (st != ST_IDLE);
    lk_valid  = (st == ST_WALK) && !wb_full;
    lk_idx    = cur_q;
    lk_clr    = lk_valid && lk_hit;
    flush_go  = (st == ST_FLUSH) && !wb_full;
    notify_go = (st == ST_NOTE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cur_q  <= '0;
      stop_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          cur_q  <= first_idx;
          stop_q <= last_idx;
          st     <= ST_WALK;
        end
        ST_WALK: if (!wb_full) begin
          if (cur_q == stop_q) st <= ST_FLUSH;
          else                 cur_q <= cur_q + 1'b1;
        end
        ST_FLUSH: if (!wb_full) st <= ST_NOTE;
        default:  st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rfe_wbport.sv
module rfe_wbport
  import rfe_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 14,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_go,
  input  logic              line_dirty,
  input  logic [ADDR_W-1:0] line_idx,
  input  logic              flush_go,
  input  logic [ADDR_W-1:0] base,
  input  logic [SIZE_W-1:0] size,
  output logic              wb_valid,
  output logic [1:0]        wb_cmd,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [SIZE_W-1:0] wb_size
);
  localparam int LINE_LG = $clog2(LINE_BYTES);

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
      wb_cmd   <= WB_NONE;
      wb_addr  <= '0;
      wb_size  <= '0;
    end else begin
      wb_valid <= line_go || flush_go;
      if (line_go) begin
        wb_cmd  <= line_dirty ? WB_WRITEBACK : WB_INVALIDATE;
        wb_addr <= line_idx << LINE_LG;
        wb_size <= SIZE_W'(LINE_BYTES);
      end else if (flush_go) begin
        wb_cmd  <= WB_FLUSH;
        wb_addr <= base;
        wb_size <= size;
      end
    end
  end
endmodule

// File: rtl/rfe_notify.sv
module rfe_notify #(
  parameter int ADDR_W  = 32,
  parameter int SIZE_W  = 14,
  parameter bit IS_LAST = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              notify_go,
  input  logic [ADDR_W-1:0] base,
  input  logic [SIZE_W-1:0] size,
  output logic              fwd_valid,
  output logic              cpl_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [SIZE_W-1:0] out_size
);
  logic pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q  <= 1'b0;
      out_addr <= '0;
      out_size <= '0;
    end else begin
      pulse_q <= notify_go;
      if (notify_go) begin
        out_addr <= base;
        out_size <= size;
      end
    end
  end

  generate
    if (IS_LAST) begin : g_last
      assign cpl_valid = pulse_q;
      assign fwd_valid = 1'b0;
    end else begin : g_inner
      assign fwd_valid = pulse_q;
      assign cpl_valid = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/range_flush_engine.sv
module range_flush_engine #(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 14,
  parameter int LINE_BYTES = 64,
  parameter bit IS_LAST    = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  output logic              req_ready,
  output logic              lk_valid,
  output logic [ADDR_W-1:0] lk_line,
  input  logic              lk_hit,
  input  logic              lk_dirty,
  output logic              lk_clr,
  input  logic              wb_full,
  output logic              wb_valid,
  output logic [1:0]        wb_cmd,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [SIZE_W-1:0] wb_size,
  output logic              fwd_valid,
  output logic              cpl_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [SIZE_W-1:0] out_size
);
  localparam int LINE_LG = $clog2(LINE_BYTES);

  logic              busy;
  logic              start;
  logic              flush_go;
  logic              notify_go;
  logic [ADDR_W-1:0] first_idx;
  logic [ADDR_W-1:0] last_idx;
  logic [ADDR_W-1:0] base_q;
  logic [SIZE_W-1:0] size_q;

  assign req_ready = !busy;
  assign start     = req_valid && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      size_q <= '0;
    end else if (start) begin
      base_q <= req_addr;
      size_q <= req_size;
    end
  end

  rfe_range #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .LINE_LG(LINE_LG)) u_range (
    .base(req_addr), .size(req_size),
    .first_idx(first_idx), .last_idx(last_idx)
  );

  rfe_walker #(.ADDR_W(ADDR_W)) u_walker (
    .clk(clk), .rst(rst), .start(start),
    .first_idx(first_idx), .last_idx(last_idx),
    .wb_full(wb_full), .lk_hit(lk_hit),
    .busy(busy), .lk_valid(lk_valid), .lk_idx(lk_line), .lk_clr(lk_clr),
    .flush_go(flush_go), .notify_go(notify_go)
  );

  rfe_wbport #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .LINE_BYTES(LINE_BYTES)) u_wbport (
    .clk(clk), .rst(rst),
    .line_go(lk_clr), .line_dirty(lk_dirty), .line_idx(lk_line),
    .flush_go(flush_go), .base(base_q), .size(size_q),
    .wb_valid(wb_valid), .wb_cmd(wb_cmd), .wb_addr(wb_addr), .wb_size(wb_size)
  );

  rfe_notify #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .IS_LAST(IS_LAST)) u_notify (
    .clk(clk), .rst(rst), .notify_go(notify_go),
    .base(base_q), .size(size_q),
    .fwd_valid(fwd_valid), .cpl_valid(cpl_valid),
    .out_addr(out_addr), .out_size(out_size)
  );
endmodule

// File: rtl/rfe_checker.sv
module rfe_checker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              lk_valid,
  input logic              lk_clr,
  input logic              wb_full,
  input logic              wb_valid,
  input logic [1:0]        wb_cmd,
  input logic [ADDR_W-1:0] wb_addr,
  input logic              fwd_valid,
  input logic              cpl_valid
);
  AST_CLR_THEN_ENQ: assert property (@(posedge clk) disable iff (rst)
    lk_clr |=> (wb_valid && (wb_cmd == 2'd1 || wb_cmd == 2'd2))); // R3

  AST_FULL_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
    wb_full |=> !wb_valid); // R8

  AST_LOOKUP_BUSY: assert property (@(posedge clk) disable iff (rst)
    lk_valid |-> !req_ready); // R9

  AST_NOTE_AFTER_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (fwd_valid || cpl_valid) |-> $past(wb_valid && wb_cmd == 2'd3)); // R6

  AST_ONE_NOTE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fwd_valid, cpl_valid})); // R6

  AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && wb_cmd != 2'd3) |-> ((wb_addr % LINE_BYTES) == 0)); // R10
endmodule

bind range_flush_engine rfe_checker #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .lk_valid(lk_valid),
  .lk_clr(lk_clr), .wb_full(wb_full), .wb_valid(wb_valid), .wb_cmd(wb_cmd),
  .wb_addr(wb_addr), .fwd_valid(fwd_valid), .cpl_valid(cpl_valid)
);

// File: tb/range_flush_engine_bench.sv
module range_flush_engine_bench;
  localparam int AW = 32;
  localparam int SW = 14;
  localparam int LB = 64;
  localparam int NV = 6;
  // base, size, lines, writebacks, invalidates (hit = idx bit1, dirty = idx bit0)
  localparam int unsigned VEC [NV][5] = '{
    '{32'h1000,    4,   1,  0,  0},
    '{32'h1000,  256,   4,  1,  1},
    '{32'h103C,    8,   2,  0,  0},
    '{32'h10C0,  128,   2,  1,  0},
    '{32'h0000, 8192, 128, 32, 32},
    '{32'h20BE,    4,   2,  1,  1}
  };

  logic clk = 0, rst = 1;
  logic req_valid = 0, wb_full = 0;
  logic [AW-1:0] req_addr = 0;
  logic [SW-1:0] req_size = 0;
  logic req_ready, lk_valid, lk_clr, wb_valid, fwd_valid, cpl_valid;
  logic [AW-1:0] lk_line, wb_addr, out_addr;
  logic [SW-1:0] wb_size, out_size;
  logic [1:0] wb_cmd;
  logic rdy_l, lkv_l, clr_l, wbv_l, fwd_l, cpl_l;
  logic [AW-1:0] lkl_l, wba_l, oa_l;
  logic [SW-1:0] wbs_l, os_l;
  logic [1:0] wbc_l;

  always #2 clk = ~clk;

  range_flush_engine #(.ADDR_W(AW), .SIZE_W(SW), .LINE_BYTES(LB)) u_range_flush_engine (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
    .req_ready(req_ready), .lk_valid(lk_valid), .lk_line(lk_line),
    .lk_hit(lk_line[1]), .lk_dirty(lk_line[0]), .lk_clr(lk_clr), .wb_full(wb_full),
    .wb_valid(wb_valid), .wb_cmd(wb_cmd), .wb_addr(wb_addr), .wb_size(wb_size),
    .fwd_valid(fwd_valid), .cpl_valid(cpl_valid), .out_addr(out_addr), .out_size(out_size));

  range_flush_engine #(.ADDR_W(AW), .SIZE_W(SW), .LINE_BYTES(LB), .IS_LAST(1'b1)) u_range_flush_engine_last (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
    .req_ready(rdy_l), .lk_valid(lkv_l), .lk_line(lkl_l),
    .lk_hit(lkl_l[1]), .lk_dirty(lkl_l[0]), .lk_clr(clr_l), .wb_full(wb_full),
    .wb_valid(wbv_l), .wb_cmd(wbc_l), .wb_addr(wba_l), .wb_size(wbs_l),
    .fwd_valid(fwd_l), .cpl_valid(cpl_l), .out_addr(oa_l), .out_size(os_l));

  int checks = 0, fails = 0, cyc = 0, nreq = 0;
  bit done = 0;
  int lk_cnt, first_line, prev_line, ord_err, clr_cnt, full_lk_err;
  int wbk_cnt, inv_cnt, fl_cnt, after_err, addr_err, t1;
  int cpl_cnt = 0, fwdl_cnt = 0, bad_cpl = 0;
  logic [AW-1:0] fl_addr, fwd_a;
  logic [SW-1:0] fl_size;
  bit fl_seen, fwd_seen;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic clear_mon();
    lk_cnt = 0; first_line = -1; prev_line = 0; ord_err = 0; clr_cnt = 0; full_lk_err = 0;
    wbk_cnt = 0; inv_cnt = 0; fl_cnt = 0; after_err = 0; addr_err = 0; t1 = 0;
    fl_seen = 0; fwd_seen = 0; fl_addr = 0; fl_size = 0; fwd_a = 0;
  endtask

  always @(negedge clk) if (!rst) begin
    if (lk_valid) begin
      if (lk_cnt == 0) first_line = int'(lk_line);
      else if (int'(lk_line) != prev_line + 1) ord_err++;
      prev_line = int'(lk_line);
      lk_cnt++;
      if (lk_clr) clr_cnt++;
      if (wb_full) full_lk_err++;
    end
    if (wb_valid) begin
      if (wb_cmd == 2'd3) begin
        fl_cnt++; fl_seen = 1; fl_addr = wb_addr; fl_size = wb_size;
      end else begin
        if (fl_seen) after_err++;
        if ((wb_addr % LB) != 0) addr_err++;
        if (wb_cmd == 2'd1) wbk_cnt++;
        else if (wb_cmd == 2'd2) inv_cnt++;
      end
    end
    if (fwd_valid) begin fwd_seen = 1; t1 = cyc; fwd_a = out_addr; end
    if (cpl_valid) bad_cpl++;
    if (cpl_l) cpl_cnt++;
    if (fwd_l) fwdl_cnt++;
  end

  task automatic run(input int unsigned base, input int unsigned size, input int lines,
                     input int wbk, input int inv, input int stall, input bit intr);
    int t0;
    clear_mon();
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready before request", req_ready, 1);
    req_valid = 1; req_addr = base; req_size = SW'(size);
    @(negedge clk);
    t0 = cyc; req_valid = 0; nreq++;
    chk(req_ready == 1'b0, "R9 busy after accept", req_ready, 0);
    if (stall > 0) begin
      wb_full = 1;
      repeat (stall) @(negedge clk);
      wb_full = 0;
    end
    if (intr) begin
      repeat (3) @(negedge clk);
      req_valid = 1; req_addr = 32'h9000; req_size = 64;
      @(negedge clk);
      req_valid = 0;
    end
    while (!fwd_seen) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(lk_cnt == lines, "R2 lookup count", lk_cnt, lines);
    chk(first_line == int'(base / LB), "R10 first line", first_line, base / LB);
    chk(ord_err == 0, "R2 ascending order", ord_err, 0);
    chk(wbk_cnt == wbk, "R3 writebacks", wbk_cnt, wbk);
    chk(inv_cnt == inv, "R4 invalidates", inv_cnt, inv);
    chk(clr_cnt == wbk + inv, "R3 valid clears", clr_cnt, wbk + inv);
    chk(addr_err == 0, "R10 line address aligned", addr_err, 0);
    chk(fl_cnt == 1, "R5 one flush entry", fl_cnt, 1);
    chk(fl_addr == base && fl_size == SW'(size), "R5 flush entry fields", fl_addr, base);
    chk(after_err == 0, "R5 flush entry last", after_err, 0);
    chk(fwd_a == base, "R6 forwarded base", fwd_a, base);
    chk(t1 - t0 == lines + 2 + stall, "R7 fixed latency", t1 - t0, lines + 2 + stall);
    chk(full_lk_err == 0, "R8 no lookup while full", full_lk_err, 0);
  endtask

  initial begin
    clear_mon();
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(!lk_valid && !lk_clr && !wb_valid && !fwd_valid && !cpl_valid,
        "R1 outputs idle", {lk_valid, lk_clr, wb_valid, fwd_valid, cpl_valid}, 0);
    for (int i = 0; i < NV; i++)
      run(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], 0, 1'b0);
    // R8: back-pressure for 5 cycles at the start of the walk
    run(32'h1000, 256, 4, 1, 1, 5, 1'b0);
    // R9: request arriving mid-walk is ignored
    run(32'h0000, 8192, 128, 32, 32, 0, 1'b1);
    chk(bad_cpl == 0, "R6 inner level gives no completion", bad_cpl, 0);
    chk(cpl_cnt == nreq, "R6 last level completions", cpl_cnt, nreq);
    chk(fwdl_cnt == 0, "R6 last level never forwards", fwdl_cnt, 0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(1'b0, "watchdog", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule